// File: doc/BRIEF.md
# Storage Controller Status Register Bank

This block is the byte-wide register file that sits behind the host bus bridge of a storage controller. Each cycle the bridge can present one access: a read returns one byte and a write stores one byte. Most locations are plain storage. Several have side effects when they are read: status bytes clear themselves, and one read consumes a pending signal flag that lives in another register. The bank also holds fixed identification bytes, a scratch array of 32-bit words addressed one byte lane at a time, and a link status byte that depends on a control bit.

The script engine and the bus phase logic are outside this block. They report events as one-cycle set pulses on three status inputs and a signal-request input. The bank ORs the masked status bytes into one interrupt level and registers it before it drives the pin, so the level follows every status change, including the clear caused by a read.

Read data and an error flag are registered. Both appear in the cycle after the edge that accepts the request. The side effects of a read take place on that same accepting edge.

Top module: `ctl_status_regs`

## Requirements
- R1: After reset the command byte (0x27) reads 0x40, the DMA status byte is 0 (so a read of 0x0C returns 0x80), both bus status bytes (0x42, 0x43) read 0, irq is low, and rsp_valid and rsp_err are low.
- R2: A read accepted on a clock edge drives rsp_valid high with rsp_data for the following cycle only. rsp_err has the same timing for reads and writes. A write never raises rsp_valid.
- R3: A read of 0x0C returns the DMA status byte with bit 7 forced to 1. On the accepting edge the byte clears only if bit 2 (interrupt flag) of the interrupt status byte at 0x14 is 0. Otherwise it keeps its value.
- R4: A read of 0x42 or 0x43 returns the stored bus status byte and clears it on every read, whatever the interrupt flag holds.
- R5: A read of 0x1A returns bit 0 and bit 3 set, bit 1 equal to the stored writable bit (written through wdata bit 1), and bit 6 equal to the signal flag, bit 5 of 0x14. The read clears that signal flag.
- R6: Fixed reads: 0x07 gives 0x7F, 0x08 gives 0x00, 0x18 gives 0xFF, 0x46 and 0x47 give 0x0F, and 0x52 gives 0xE0. Writes to these offsets, and to 0x0C, 0x0F, 0x42 and 0x43, are ignored and raise no error.
- R7: 0x0F reads 0x00 when bit 4 of the link control byte at 0x01 is set, and 0x02 otherwise.
- R8: Scratch word 0 occupies 0x34 to 0x37. Word n (n from 1) occupies 0x58+4n to 0x5B+4n, which is 0x5C to 0x9F for the default of 18 words. The byte lane is address bits 1:0. A write replaces only the addressed byte.
- R9: A read of an unmapped offset (for example 0x15, 0x58 or 0xA0) returns 0xFF with rsp_err. A write there changes nothing and raises rsp_err.
- R10: Set pulses on dma_evt, scsi0_evt and scsi1_evt OR into their status bytes on the next edge. A pulse that coincides with a clearing read survives that clear, and the read returns the old value.
- R11: irq goes high one edge after the edge that makes any of (DMA status & 0x39), (0x42 & 0x40) or (0x43 & 0x41) nonzero. It goes low one edge after they all become zero.
- R12: Writes to 0x14 store the byte. A sigp_req pulse sets bit 5 of 0x14 on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 8 | Write data |
| dma_evt | input | 8 | Set pulses for the DMA status byte |
| scsi0_evt | input | 8 | Set pulses for bus status byte 0 |
| scsi1_evt | input | 8 | Set pulses for bus status byte 1 |
| sigp_req | input | 1 | Pulse that raises the signal flag |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 8 | Read data |
| rsp_err | output | 1 | Access hit an unmapped offset |
| irq | output | 1 | Registered interrupt level |

## Verification
A response is due in the cycle after its request is accepted. The bench records which edges accepted a request and pops one expected item from its scoreboard only at the falling edge after such an edge. Any response at other times counts as a miscompare. A set pulse becomes visible to the next read after one edge. irq needs one further edge beyond the edge that changes a status or enable byte, so every irq check looks first at the cycle where the old level must still hold and then at the following cycle. Clear-on-read and the interrupt-flag hold are each checked with a second read of the same byte.

// File: rtl/ctl_regs_pkg.sv
package ctl_regs_pkg;
    localparam int ADDR_W = 8;
    localparam int BYTE_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam addr_t OFF_CTL1 = 8'h01;
    localparam addr_t OFF_GPIN = 8'h07;
    localparam addr_t OFF_REV  = 8'h08;
    localparam addr_t OFF_DSTS = 8'h0C;
    localparam addr_t OFF_LINK = 8'h0F;
    localparam addr_t OFF_ISTS = 8'h14;
    localparam addr_t OFF_TST0 = 8'h18;
    localparam addr_t OFF_TST2 = 8'h1A;
    localparam addr_t OFF_DCMD = 8'h27;
    localparam addr_t OFF_DIEN = 8'h39;
    localparam addr_t OFF_SIE0 = 8'h40;
    localparam addr_t OFF_SIE1 = 8'h41;
    localparam addr_t OFF_SIS0 = 8'h42;
    localparam addr_t OFF_SIS1 = 8'h43;
    localparam addr_t OFF_MAC  = 8'h46;
    localparam addr_t OFF_GPC  = 8'h47;
    localparam addr_t OFF_TST4 = 8'h52;

    localparam addr_t SCR_LOW_BASE    = 8'h34;
    localparam addr_t SCR_HIGH_ORIGIN = 8'h58;

    localparam int ISTS_FLAG_BIT  = 2;
    localparam int ISTS_SIG_BIT   = 5;
    localparam int CTL1_CONN_BIT  = 4;
    localparam int DSTS_EMPTY_BIT = 7;
    localparam int TST2_ACK_BIT   = 0;
    localparam int TST2_KEEP_BIT  = 1;
    localparam int TST2_CM_BIT    = 3;
    localparam int TST2_SIG_BIT   = 6;

    localparam byte_t GPIN_VAL  = 8'h7F;
    localparam byte_t REV_VAL   = 8'h00;
    localparam byte_t TST0_VAL  = 8'hFF;
    localparam byte_t MAC_VAL   = 8'h0F;
    localparam byte_t TST4_VAL  = 8'hE0;
    localparam byte_t DCMD_RST  = 8'h40;
    localparam byte_t LINK_UP   = 8'h00;
    localparam byte_t LINK_DOWN = 8'h02;
    localparam byte_t MISS_VAL  = 8'hFF;

    typedef struct packed {
        byte_t ctl1;
        byte_t ists;
        logic  tst2_keep;
        byte_t dcmd;
        byte_t dsts;
        byte_t dien;
        byte_t sie0;
        byte_t sie1;
        byte_t sis0;
        byte_t sis1;
        logic  rsp_valid;
        logic  rsp_err;
        byte_t rsp_data;
    } bank_t;
endpackage

// File: rtl/ctl_scratch.sv
module ctl_scratch
    import ctl_regs_pkg::*;
#(
    parameter int WORDS = 18
) (
    input  logic  clk,
    input  logic  rst_n,
    input  addr_t addr,
    input  logic  wr_en,
    input  byte_t wdata,
    output byte_t rd_byte,
    output logic  hit
);
    localparam int WORD_W = 4 * BYTE_W;

    function automatic addr_t word_base(int idx);
        if (idx == 0) return SCR_LOW_BASE;
        return addr_t'(32'(SCR_HIGH_ORIGIN) + 32'(4 * idx));
    endfunction

    logic [WORDS-1:0][WORD_W-1:0] mem_d, mem_q;
    logic [WORDS-1:0]             word_hit;
    logic [1:0]                   lane;

    assign lane = addr[1:0];

    for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
        localparam addr_t WB = word_base(gi);
        assign word_hit[gi] = (addr[ADDR_W-1:2] == WB[ADDR_W-1:2]);
    end

    assign hit = |word_hit;

    always_comb begin
        mem_d   = mem_q;
        rd_byte = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (word_hit[i]) begin
                rd_byte = mem_q[i][{lane, 3'b000} +: BYTE_W];
                if (wr_en) begin
                    mem_d[i][{lane, 3'b000} +: BYTE_W] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    // R8
    scr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(word_hit));
endmodule

// File: rtl/ctl_rd_mux.sv
module ctl_rd_mux
    import ctl_regs_pkg::*;
(
    input  addr_t addr,
    input  byte_t ctl1,
    input  byte_t ists,
    input  logic  tst2_keep,
    input  byte_t dcmd,
    input  byte_t dsts,
    input  byte_t dien,
    input  byte_t sie0,
    input  byte_t sie1,
    input  byte_t sis0,
    input  byte_t sis1,
    input  byte_t scr_byte,
    input  logic  scr_hit,
    output byte_t data,
    output logic  hit
);
    always_comb begin
        data = MISS_VAL;
        hit  = 1'b1;
        case (addr)
            OFF_CTL1: data = ctl1;
            OFF_GPIN: data = GPIN_VAL;
            OFF_REV:  data = REV_VAL;
            OFF_DSTS: begin
                data = dsts;
                data[DSTS_EMPTY_BIT] = 1'b1;
            end
            OFF_LINK: data = ctl1[CTL1_CONN_BIT] ? LINK_UP : LINK_DOWN;
            OFF_ISTS: data = ists;
            OFF_TST0: data = TST0_VAL;
            OFF_TST2: begin
                data = '0;
                data[TST2_ACK_BIT]  = 1'b1;
                data[TST2_CM_BIT]   = 1'b1;
                data[TST2_KEEP_BIT] = tst2_keep;
                data[TST2_SIG_BIT]  = ists[ISTS_SIG_BIT];
            end
            OFF_DCMD: data = dcmd;
            OFF_DIEN: data = dien;
            OFF_SIE0: data = sie0;
            OFF_SIE1: data = sie1;
            OFF_SIS0: data = sis0;
            OFF_SIS1: data = sis1;
            OFF_MAC:  data = MAC_VAL;
            OFF_GPC:  data = MAC_VAL;
            OFF_TST4: data = TST4_VAL;
            default: begin
                if (scr_hit) begin
                    data = scr_byte;
                end else begin
                    data = MISS_VAL;
                    hit  = 1'b0;
                end
            end
        endcase
    end
endmodule

// File: rtl/ctl_irq.sv
module ctl_irq
    import ctl_regs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  byte_t dsts,
    input  byte_t dien,
    input  byte_t sis0,
    input  byte_t sie0,
    input  byte_t sis1,
    input  byte_t sie1,
    output logic  irq
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = (|(dsts & dien)) | (|(sis0 & sie0)) | (|(sis1 & sie1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

    // R11
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past((dsts & dien) != 0 || (sis0 & sie0) != 0 || (sis1 & sie1) != 0));
endmodule

// File: rtl/ctl_status_regs.sv
module ctl_status_regs
    import ctl_regs_pkg::*;
#(
    parameter int SCRATCH_WORDS = 18
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic [7:0] req_addr,
    input  logic [7:0] req_wdata,
    input  logic [7:0] dma_evt,
    input  logic [7:0] scsi0_evt,
    input  logic [7:0] scsi1_evt,
    input  logic       sigp_req,
    output logic       rsp_valid,
    output logic [7:0] rsp_data,
    output logic       rsp_err,
    output logic       irq
);
    bank_t bank_d, bank_q;
    byte_t scr_byte, mux_data;
    logic  scr_hit, map_hit, rd_acc, wr_acc;

    assign rd_acc = req_valid && !req_write;
    assign wr_acc = req_valid && req_write;

    ctl_scratch #(.WORDS(SCRATCH_WORDS)) u_scratch (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (req_addr),
        .wr_en   (wr_acc),
        .wdata   (req_wdata),
        .rd_byte (scr_byte),
        .hit     (scr_hit)
    );

    ctl_rd_mux u_mux (
        .addr      (req_addr),
        .ctl1      (bank_q.ctl1),
        .ists      (bank_q.ists),
        .tst2_keep (bank_q.tst2_keep),
        .dcmd      (bank_q.dcmd),
        .dsts      (bank_q.dsts),
        .dien      (bank_q.dien),
        .sie0      (bank_q.sie0),
        .sie1      (bank_q.sie1),
        .sis0      (bank_q.sis0),
        .sis1      (bank_q.sis1),
        .scr_byte  (scr_byte),
        .scr_hit   (scr_hit),
        .data      (mux_data),
        .hit       (map_hit)
    );

    always_comb begin
        bank_d = bank_q;

        bank_d.rsp_valid = rd_acc;
        bank_d.rsp_err   = req_valid && !map_hit;
        if (rd_acc) bank_d.rsp_data = mux_data;

        if (wr_acc) begin
            case (req_addr)
                OFF_CTL1: bank_d.ctl1      = req_wdata;
                OFF_ISTS: bank_d.ists      = req_wdata;
                OFF_TST2: bank_d.tst2_keep = req_wdata[TST2_KEEP_BIT];
                OFF_DCMD: bank_d.dcmd      = req_wdata;
                OFF_DIEN: bank_d.dien      = req_wdata;
                OFF_SIE0: bank_d.sie0      = req_wdata;
                OFF_SIE1: bank_d.sie1      = req_wdata;
                default: ;
            endcase
        end

        if (rd_acc) begin
            case (req_addr)
                OFF_DSTS: if (!bank_q.ists[ISTS_FLAG_BIT]) bank_d.dsts = '0;
                OFF_SIS0: bank_d.sis0 = '0;
                OFF_SIS1: bank_d.sis1 = '0;
                OFF_TST2: bank_d.ists[ISTS_SIG_BIT] = 1'b0;
                default: ;
            endcase
        end

        bank_d.dsts = bank_d.dsts | dma_evt;
        bank_d.sis0 = bank_d.sis0 | scsi0_evt;
        bank_d.sis1 = bank_d.sis1 | scsi1_evt;
        if (sigp_req) bank_d.ists[ISTS_SIG_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q      <= '0;
            bank_q.dcmd <= DCMD_RST;
        end else begin
            bank_q <= bank_d;
        end
    end

    ctl_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .dsts  (bank_q.dsts),
        .dien  (bank_q.dien),
        .sis0  (bank_q.sis0),
        .sie0  (bank_q.sie0),
        .sis1  (bank_q.sis1),
        .sie1  (bank_q.sie1),
        .irq   (irq)
    );

    assign rsp_valid = bank_q.rsp_valid;
    assign rsp_data  = bank_q.rsp_data;
    assign rsp_err   = bank_q.rsp_err;

    // R3
    dsts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && req_addr == OFF_DSTS && bank_q.ists[ISTS_FLAG_BIT])
        |=> bank_q.dsts == ($past(bank_q.dsts) | $past(dma_evt)));

    // R4
    sis0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && req_addr == OFF_SIS0) |=> bank_q.sis0 == $past(scsi0_evt));

    // R5
    sig_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && req_addr == OFF_TST2 && !sigp_req) |=> !bank_q.ists[ISTS_SIG_BIT]);

    // R9
    miss_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> rsp_data == MISS_VAL);
endmodule

// File: tb/ctl_status_regs_tb.sv
`timescale 1ns/1ps
module ctl_status_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [7:0] req_addr = '0, req_wdata = '0;
    logic [7:0] dma_evt = '0, scsi0_evt = '0, scsi1_evt = '0;
    logic       sigp_req = 1'b0;
    logic       rsp_valid, rsp_err, irq;
    logic [7:0] rsp_data;

    always #4 clk = ~clk;

    ctl_status_regs u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .dma_evt(dma_evt),
        .scsi0_evt(scsi0_evt), .scsi1_evt(scsi1_evt), .sigp_req(sigp_req),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err), .irq(irq)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    bit due = 0;
    bit         q_rd[$];
    logic [7:0] q_dat[$];
    bit         q_err[$];
    string      q_tag[$];

    always @(posedge clk) due <= rst_n && req_valid;

    always @(negedge clk) begin
        if (due) begin
            n_chk++;
            if (q_rd.size() == 0) begin
                n_bad++;
                $display("FAIL R2 unexpected response: valid=%0b err=%0b expected none", rsp_valid, rsp_err);
            end else begin
                automatic bit         e_rd  = q_rd.pop_front();
                automatic logic [7:0] e_dat = q_dat.pop_front();
                automatic bit         e_err = q_err.pop_front();
                automatic string      e_tag = q_tag.pop_front();
                if (rsp_valid !== e_rd || rsp_err !== e_err || (e_rd && rsp_data !== e_dat)) begin
                    n_bad++;
                    $display("FAIL %s: valid=%0b err=%0b data=%02h expected valid=%0b err=%0b data=%02h",
                             e_tag, rsp_valid, rsp_err, rsp_data, e_rd, e_err, e_dat);
                end
            end
        end else if (rst_n && (rsp_valid || rsp_err)) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 response without request: valid=%0b err=%0b expected 0 0", rsp_valid, rsp_err);
        end
    end

    task automatic acc(bit w, logic [7:0] a, logic [7:0] d, logic [7:0] exp, bit err, string tag);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        q_rd.push_back(!w); q_dat.push_back(exp); q_err.push_back(err); q_tag.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
        acc(1'b0, a, 8'h00, exp, 1'b0, tag);
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d, string tag);
        acc(1'b1, a, d, 8'h00, 1'b0, tag);
    endtask

    task automatic chk_bit(logic act, logic exp, string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic pulse(int which, logic [7:0] v);
        case (which)
            0: dma_evt = v;
            1: scsi0_evt = v;
            2: scsi1_evt = v;
            default: sigp_req = 1'b1;
        endcase
        @(negedge clk);
        dma_evt = '0; scsi0_evt = '0; scsi1_evt = '0; sigp_req = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_bit(irq, 1'b0, "R1 irq in reset");
        chk_bit(rsp_valid, 1'b0, "R1 rsp_valid in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_bit(rsp_err, 1'b0, "R1 rsp_err after reset");

        rd(8'h27, 8'h40, "R1 command byte reset");
        rd(8'h0C, 8'h80, "R1 dma status reset");
        rd(8'h42, 8'h00, "R1 bus status 0 reset");
        rd(8'h43, 8'h00, "R1 bus status 1 reset");
        chk_bit(irq, 1'b0, "R1 irq after reset");

        rd(8'h07, 8'h7F, "R6 fixed 0x07");
        rd(8'h08, 8'h00, "R6 fixed 0x08");
        rd(8'h18, 8'hFF, "R6 fixed 0x18");
        rd(8'h46, 8'h0F, "R6 fixed 0x46");
        rd(8'h47, 8'h0F, "R6 fixed 0x47");
        rd(8'h52, 8'hE0, "R6 fixed 0x52");
        wr(8'h07, 8'h00, "R6 write to fixed ignored");
        rd(8'h07, 8'h7F, "R6 fixed unchanged");
        wr(8'h42, 8'hFF, "R6 write to bus status ignored");
        rd(8'h42, 8'h00, "R6 bus status unchanged");

        rd(8'h0F, 8'h02, "R7 link down");
        wr(8'h01, 8'h10, "R7 set connected");
        rd(8'h01, 8'h10, "R7 control readback");
        rd(8'h0F, 8'h00, "R7 link up");
        wr(8'h01, 8'h00, "R7 clear connected");
        rd(8'h0F, 8'h02, "R7 link down again");

        pulse(0, 8'h05);
        rd(8'h0C, 8'h85, "R3 dma status with empty bit");
        rd(8'h0C, 8'h80, "R3 dma status cleared");
        wr(8'h14, 8'h04, "R12 set interrupt flag");
        rd(8'h14, 8'h04, "R12 interrupt status readback");
        pulse(0, 8'h02);
        rd(8'h0C, 8'h82, "R3 read with flag set");
        rd(8'h0C, 8'h82, "R3 held while flag set");
        pulse(2, 8'h80);
        rd(8'h43, 8'h80, "R4 bus status 1 with flag set");
        rd(8'h43, 8'h00, "R4 bus status 1 cleared regardless");
        wr(8'h14, 8'h00, "R12 clear interrupt flag");
        rd(8'h0C, 8'h82, "R3 read after flag cleared");
        rd(8'h0C, 8'h80, "R3 cleared after flag cleared");

        pulse(1, 8'h11);
        rd(8'h42, 8'h11, "R4 bus status 0 value");
        rd(8'h42, 8'h00, "R4 bus status 0 cleared");

        pulse(1, 8'h02);
        scsi0_evt = 8'h04;
        rd(8'h42, 8'h02, "R10 read coinciding with event");
        scsi0_evt = 8'h00;
        rd(8'h42, 8'h04, "R10 event survived clear");

        rd(8'h1A, 8'h09, "R5 test byte default");
        wr(8'h1A, 8'hFF, "R5 write test byte");
        rd(8'h1A, 8'h0B, "R5 only keep bit stored");
        wr(8'h14, 8'h20, "R12 set signal flag by write");
        rd(8'h1A, 8'h4B, "R5 signal flag reported");
        rd(8'h14, 8'h00, "R5 signal flag consumed");
        rd(8'h1A, 8'h0B, "R5 signal flag gone");
        pulse(3, 8'h00);
        rd(8'h14, 8'h20, "R12 signal request sets flag");
        rd(8'h1A, 8'h4B, "R5 requested flag reported");
        rd(8'h14, 8'h00, "R5 requested flag consumed");

        wr(8'h5C, 8'hA1, "R8 write word1 lane0");
        wr(8'h5F, 8'hD4, "R8 write word1 lane3");
        wr(8'h5D, 8'h3C, "R8 write word1 lane1");
        rd(8'h5C, 8'hA1, "R8 lane0 kept");
        rd(8'h5D, 8'h3C, "R8 lane1");
        rd(8'h5E, 8'h00, "R8 lane2 untouched");
        rd(8'h5F, 8'hD4, "R8 lane3");
        wr(8'h9F, 8'h77, "R8 write top word lane3");
        rd(8'h9F, 8'h77, "R8 top word lane3");
        rd(8'h9C, 8'h00, "R8 top word lane0 untouched");
        wr(8'h34, 8'h12, "R8 write word0");
        rd(8'h34, 8'h12, "R8 word0 lane0");
        rd(8'h60, 8'h00, "R8 word2 untouched");

        acc(1'b0, 8'h58, 8'h00, 8'hFF, 1'b1, "R9 read below scratch");
        acc(1'b0, 8'hA0, 8'h00, 8'hFF, 1'b1, "R9 read above scratch");
        acc(1'b0, 8'h15, 8'h00, 8'hFF, 1'b1, "R9 read hole");
        acc(1'b1, 8'h58, 8'h99, 8'h00, 1'b1, "R9 write below scratch");
        rd(8'h5C, 8'hA1, "R9 scratch untouched by bad write");
        acc(1'b1, 8'hA0, 8'h55, 8'h00, 1'b1, "R9 write above scratch");
        rd(8'h9F, 8'h77, "R9 top word untouched by bad write");

        wr(8'h39, 8'h01, "R11 enable dma bit0");
        chk_bit(irq, 1'b0, "R11 enable alone no irq");
        pulse(0, 8'h01);
        chk_bit(irq, 1'b0, "R11 irq registered stage");
        @(negedge clk);
        chk_bit(irq, 1'b1, "R11 irq raised");
        rd(8'h0C, 8'h81, "R11 read dma status");
        chk_bit(irq, 1'b1, "R11 irq one cycle after clear");
        @(negedge clk);
        chk_bit(irq, 1'b0, "R11 irq dropped after clear");
        wr(8'h14, 8'h04, "R11 flag set");
        pulse(0, 8'h01);
        rd(8'h0C, 8'h81, "R11 read with flag");
        @(negedge clk);
        chk_bit(irq, 1'b1, "R11 irq kept while flag set");
        wr(8'h14, 8'h00, "R11 flag cleared");
        rd(8'h0C, 8'h81, "R11 read clears");
        @(negedge clk);
        chk_bit(irq, 1'b0, "R11 irq low after clear");
        wr(8'h39, 8'h00, "R11 disable dma");

        pulse(1, 8'h08);
        @(negedge clk);
        chk_bit(irq, 1'b0, "R11 masked bus status no irq");
        wr(8'h40, 8'h08, "R11 enable bus bit3");
        @(negedge clk);
        chk_bit(irq, 1'b1, "R11 irq after enable");
        rd(8'h42, 8'h08, "R11 bus status value");
        @(negedge clk);
        chk_bit(irq, 1'b0, "R11 irq after bus read");

        @(negedge clk);
        n_chk++;
        if (q_rd.size() != 0) begin
            n_bad++;
            $display("FAIL R2 responses missing: %0d pending expected 0", q_rd.size());
        end
        if (!finished) begin
            finished = 1;
            summary();
            $finish;
        end
    end
endmodule